// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Sequencer

This block is a synchronous behavioural model of the control side of a byte-wide static RAM that carries a shadow nonvolatile copy of every word. On each clock edge it samples four active-low control pins (chip select, write strobe, output enable and a nonvolatile-mode select) and decodes them into deselect, read, write, store, recall or no operation. Reads and writes act on the live array at once. A store copies the whole live array into the shadow copy. A recall clears the live array and then reloads it from the shadow copy.

Store and recall are started only when the pins move into the required state. Each one then runs for a fixed, parameterised number of cycles. During that time the pins are ignored and the read bus is not driven. Three digital supply flags drive the power logic. A drop below the reset level latches a pending recall, and that recall is replayed as a longer restore once the supply is back above the sense level. A store-inhibit flag suppresses store requests. A reset of the block stands for power-on, so it always leaves a restore pending. The pins are plain control pins. The block has no streaming interface and applies no back-pressure.

Top module: `nvs_seq_top`

## Requirements
- R1: Pin decode, with every pin active low: `ce_n`=1 deselects. With `nv_n`=1: `we_n`=0 is a write, whatever `oe_n` is; `we_n`=1 with `oe_n`=0 is a read; `we_n`=1 with `oe_n`=1 is no operation. With `nv_n`=0: `we_n`=0 with `oe_n`=1 is a store; `we_n`=1 with `oe_n`=0 is a recall; the other two combinations are no operation. A no-operation state writes nothing, starts nothing and leaves `rdata_oe` low.
- R2: A read state sampled at an idle edge gives `rdata_oe`=1 and `rdata` equal to the word at `addr` after that edge. A write state sampled at an idle edge stores `wdata` at `addr`.
- R3: After any edge at which `we_n`=0 or `ce_n`=1 was sampled, `rdata_oe` is 0.
- R4: A store replaces the entire shadow copy with the live array. A recall leaves the live array equal to the shadow copy and leaves the shadow copy unchanged, so a second recall restores the same contents.
- R5: A store or recall starts only at an edge where the decoded state differs from the one seen at the last edge with no operation running. A state still held when an operation ends does not start a second one.
- R6: `busy` is high for exactly STORE_CYC cycles for a store and exactly RECALL_CYC cycles for a recall. While an operation runs, writes, reads and new requests on the pins have no effect, and `rdata_oe` stays 0.
- R7: After an operation ends, the pin state is acted on at the first edge after `busy` falls. A read state held there drives `rdata_oe` high with valid data one cycle after `busy` falls.
- R8: While `pwr_below_inhibit` is 1, a store state does not start a store. Clearing the flag while the pins stay in that state starts nothing.
- R9: `pwr_below_reset`=1 latches a pending recall, which raises `busy` at the next edge. When `pwr_sense_ok` is 1 and the supply is not below the reset level, the pending recall runs for RESTORE_CYC cycles and then leaves the live array equal to the shadow copy. A dip in `pwr_sense_ok` without `pwr_below_reset` starts no recall.
- R10: Reset leaves a restore pending. `busy` is 1 and `rdata_oe` is 0 from reset until the restore finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, modelling power-on |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| nv_n | input | 1 | Nonvolatile-mode select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rdata_oe | output | 1 | Read bus drive enable; 0 means high impedance |
| busy | output | 1 | A store, recall or restore is running or pending |
| pwr_sense_ok | input | 1 | Supply above the sense level |
| pwr_below_reset | input | 1 | Supply below the reset level |
| pwr_below_inhibit | input | 1 | Supply below the store-inhibit level |

## Verification
Every pin state is sampled at a rising edge, so read data and `rdata_oe` are due one cycle after the stimulus. `busy` rises one cycle after a qualifying store, recall or supply-reset event. The bench drives inputs and samples outputs on falling edges, so each result is read at the first falling edge after the rising edge that produces it. Operation length is measured by counting the falling edges at which `busy` is high, and the effect of the pin state that waits out an operation is checked at the first and second falling edges after `busy` drops.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    M_DESEL, M_READ, M_WRITE, M_STORE, M_RECALL, M_NOP
  } nvs_mode_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_STORE, OP_RECALL, OP_RESTORE
  } nvs_op_e;
endpackage

// File: rtl/nvs_mode_decode.sv
module nvs_mode_decode
  import nvs_pkg::*;
(
  input  logic      ce_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      nv_n,
  output nvs_mode_e mode
);
  always_comb begin
    if (ce_n) begin
      mode = M_DESEL;
    end else if (nv_n) begin
      if (!we_n)      mode = M_WRITE;
      else if (!oe_n) mode = M_READ;
      else            mode = M_NOP;
    end else begin
      if (!we_n && oe_n)      mode = M_STORE;
      else if (we_n && !oe_n) mode = M_RECALL;
      else                    mode = M_NOP;
    end
  end
endmodule

// File: rtl/nvs_op_timer.sv
module nvs_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_len - CNT_W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              store_en,
  input  logic              clear_en,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] live_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] live_q;
    logic [DATA_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                live_q <= '0;
      else if (clear_en)                         live_q <= '0;
      else if (load_en)                          live_q <= shadow_q;
      else if (wr_en && wr_addr == ADDR_W'(i))   live_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shadow_q <= '0;
      else if (store_en) shadow_q <= live_q;
    end

    assign live_flat[i*DATA_W +: DATA_W] = live_q;
  end

  assign rd_data = live_flat[rd_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/nvs_seq_top.sv
module nvs_seq_top
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int STORE_CYC   = 2_000_000,
  parameter int RECALL_CYC  = 4_000,
  parameter int RESTORE_CYC = 110_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              nv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              busy,
  input  logic              pwr_sense_ok,
  input  logic              pwr_below_reset,
  input  logic              pwr_below_inhibit
);
  localparam int MAX_A   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_CYC = (MAX_A > RESTORE_CYC) ? MAX_A : RESTORE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  nvs_mode_e         mode;
  nvs_mode_e         prev_mode_q;
  nvs_op_e           op_kind;
  logic              rcl_pend_q;
  logic              op_active, idle, state_new;
  logic              start_store, start_recall, start_restore, start_any;
  logic              do_read, do_write, expire;
  logic [CNT_W-1:0]  start_len;
  logic [DATA_W-1:0] arr_rd;

  nvs_mode_decode u_dec (
    .ce_n (ce_n),
    .we_n (we_n),
    .oe_n (oe_n),
    .nv_n (nv_n),
    .mode (mode)
  );

  assign op_active     = (op_kind != OP_NONE);
  assign idle          = !op_active && !rcl_pend_q;
  assign state_new     = (mode != prev_mode_q);
  assign start_restore = !op_active && rcl_pend_q && pwr_sense_ok && !pwr_below_reset;
  assign start_store   = idle && state_new && (mode == M_STORE) && !pwr_below_inhibit;
  assign start_recall  = idle && state_new && (mode == M_RECALL);
  assign start_any     = start_restore || start_store || start_recall;
  assign do_read       = idle && (mode == M_READ);
  assign do_write      = idle && (mode == M_WRITE);

  always_comb begin
    if (start_restore)    start_len = CNT_W'(RESTORE_CYC);
    else if (start_store) start_len = CNT_W'(STORE_CYC);
    else                  start_len = CNT_W'(RECALL_CYC);
  end

  nvs_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_any),
    .load_len (start_len),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              op_kind <= OP_NONE;
    else if (start_restore)  op_kind <= OP_RESTORE;
    else if (start_store)    op_kind <= OP_STORE;
    else if (start_recall)   op_kind <= OP_RECALL;
    else if (expire)         op_kind <= OP_NONE;
  end

  // Power-on and brown-out recall request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rcl_pend_q <= 1'b1;
    else if (pwr_below_reset) rcl_pend_q <= 1'b1;
    else if (start_restore)   rcl_pend_q <= 1'b0;
  end

  // Last pin state seen outside an operation: multi-trigger guard
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prev_mode_q <= M_NOP;
    else if (!op_active) prev_mode_q <= mode;
  end

  nvs_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (do_write),
    .wr_addr  (addr),
    .wr_data  (wdata),
    .store_en (expire && op_kind == OP_STORE),
    .clear_en (start_recall || start_restore),
    .load_en  (expire && (op_kind == OP_RECALL || op_kind == OP_RESTORE)),
    .rd_addr  (addr),
    .rd_data  (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_oe <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata_oe <= do_read;
      if (do_read) rdata <= arr_rd;
    end
  end

  assign busy = op_active || rcl_pend_q;
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk
  import nvs_pkg::*;
#(
  parameter int STORE_CYC   = 2_000_000,
  parameter int RECALL_CYC  = 4_000,
  parameter int RESTORE_CYC = 110_000
) (
  input logic    clk,
  input logic    rst_n,
  input logic    ce_n,
  input logic    we_n,
  input logic    busy,
  input logic    rdata_oe,
  input logic    pwr_below_reset,
  input logic    pwr_below_inhibit,
  input nvs_op_e op_kind
);
  logic [31:0] run_len;
  logic [31:0] exp_len;
  nvs_op_e     kind_q;
  logic        act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      kind_q  <= OP_NONE;
      act_q   <= 1'b0;
    end else begin
      act_q   <= (op_kind != OP_NONE);
      run_len <= (op_kind != OP_NONE) ? run_len + 32'd1 : 32'd0;
      if (op_kind != OP_NONE) kind_q <= op_kind;
    end
  end

  always_comb begin
    case (kind_q)
      OP_STORE:   exp_len = 32'(STORE_CYC);
      OP_RECALL:  exp_len = 32'(RECALL_CYC);
      OP_RESTORE: exp_len = 32'(RESTORE_CYC);
      default:    exp_len = 32'd0;
    endcase
  end

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdata_oe);

  // R3
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !rdata_oe);

  // R3
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rdata_oe);

  // R6
  op_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && op_kind == OP_NONE) |-> (run_len == exp_len));

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == OP_STORE && !act_q) |-> !$past(pwr_below_inhibit));

  // R9
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_below_reset |=> busy);
endmodule

bind nvs_seq_top nvs_seq_chk #(
  .STORE_CYC   (STORE_CYC),
  .RECALL_CYC  (RECALL_CYC),
  .RESTORE_CYC (RESTORE_CYC)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .ce_n              (ce_n),
  .we_n              (we_n),
  .busy              (busy),
  .rdata_oe          (rdata_oe),
  .pwr_below_reset   (pwr_below_reset),
  .pwr_below_inhibit (pwr_below_inhibit),
  .op_kind           (op_kind)
);

// File: tb/tb_nvs_seq_top.sv
`timescale 1ns/100ps
module tb_nvs_seq_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int SC = 24;
  localparam int RC = 8;
  localparam int RS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, nv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe, busy;
  logic pwr_sense_ok = 1'b0, pwr_below_reset = 1'b0, pwr_below_inhibit = 1'b0;

  int vectors = 0;
  int miss = 0;
  bit done = 0;
  logic [DW-1:0] live_m [DEPTH];
  logic [DW-1:0] shad_m [DEPTH];

  always #2.5 clk = ~clk;

  nvs_seq_top #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC),
                .RESTORE_CYC(RS)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .nv_n(nv_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy),
    .pwr_sense_ok(pwr_sense_ok), .pwr_below_reset(pwr_below_reset),
    .pwr_below_inhibit(pwr_below_inhibit));

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic w, input logic o, input logic n);
    ce_n = c; we_n = w; oe_n = o; nv_n = n;
  endtask

  task automatic desel;
    pins(1, 1, 1, 1);
  endtask

  // R2 R3: write with random output enable, bus must stay off
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pins(0, 0, 1'($urandom % 2), 1);
    addr = a; wdata = d;
    tick;
    chk(rdata_oe == 1'b0, "R3 write bus off", 32'(rdata_oe), 0);
    live_m[a] = d;
    desel;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string rq);
    pins(0, 1, 0, 1);
    addr = a;
    tick;
    chk(rdata_oe == 1'b1, rq, 32'(rdata_oe), 1);
    chk(rdata == live_m[a], rq, 32'(rdata), 32'(live_m[a]));
    desel;
  endtask

  task automatic verify_all(input string rq);
    for (int a = 0; a < DEPTH; a++) do_read(AW'(a), rq);
  endtask

  // counts falling edges with busy high, optionally scrambling pins
  task automatic count_busy(input bit scramble, output int n);
    n = 0;
    while (busy && n < 5000) begin
      if (scramble) begin
        pins(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
        addr = AW'($urandom); wdata = DW'($urandom);
      end
      n++;
      tick;
    end
  endtask

  task automatic start_op(input logic w, input logic o, input string rq);
    pins(0, w, o, 0);
    tick;
    chk(busy == 1'b1, rq, 32'(busy), 1);
  endtask

  task automatic copy_live_to_shad;
    for (int a = 0; a < DEPTH; a++) shad_m[a] = live_m[a];
  endtask

  task automatic copy_shad_to_live;
    for (int a = 0; a < DEPTH; a++) live_m[a] = shad_m[a];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h00C0FFEE));
    for (int a = 0; a < DEPTH; a++) begin live_m[a] = '0; shad_m[a] = '0; end

    // R10: power-on restore pending
    repeat (4) tick;
    rst_n = 1'b1;
    tick;
    chk(busy == 1'b1, "R10 busy after reset", 32'(busy), 1);
    chk(rdata_oe == 1'b0, "R10 bus off after reset", 32'(rdata_oe), 0);
    pins(0, 1, 0, 1);
    repeat (3) tick;
    chk(rdata_oe == 1'b0, "R10 read blocked while pending", 32'(rdata_oe), 0);
    chk(busy == 1'b1, "R9 pending waits for sense", 32'(busy), 1);
    desel;
    pwr_sense_ok = 1'b1;
    tick;
    count_busy(0, n);
    chk(n == RS, "R9 power-on restore length", 32'(n), RS);
    verify_all("R9 restore of blank copy");

    // R2 R3: random read/write/deselect traffic
    for (int i = 0; i < 200; i++) begin
      int sel = $urandom % 3;
      if (sel == 0) do_write(AW'($urandom), DW'($urandom));
      else if (sel == 1) do_read(AW'($urandom), "R2 random read");
      else begin
        desel; tick;
        chk(rdata_oe == 1'b0, "R3 deselect bus off", 32'(rdata_oe), 0);
      end
    end
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), DW'($urandom));

    // R1: no-operation combinations
    pins(0, 0, 0, 0); addr = 3; wdata = ~live_m[3];
    tick; chk(busy == 1'b0, "R1 nv no-op starts nothing", 32'(busy), 0);
    chk(rdata_oe == 1'b0, "R1 nv no-op bus off", 32'(rdata_oe), 0);
    pins(0, 1, 1, 0);
    tick; chk(busy == 1'b0, "R1 nv no-op oe high", 32'(busy), 0);
    pins(0, 1, 1, 1);
    tick; chk(rdata_oe == 1'b0, "R1 sram no-op bus off", 32'(rdata_oe), 0);
    desel; tick;
    do_read(3, "R1 no-op wrote nothing");

    // R5 R6: store, held state does not retrigger
    start_op(0, 1, "R5 store starts on transition");
    count_busy(0, n);
    chk(n == SC, "R6 store length", 32'(n), SC);
    copy_live_to_shad;
    repeat (5) begin
      tick;
      chk(busy == 1'b0, "R5 held store no retrigger", 32'(busy), 0);
    end
    desel; tick;

    // R4: recall restores shadow, twice
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < DEPTH; a += 3) do_write(AW'(a), DW'($urandom));
      start_op(1, 0, "R5 recall starts on transition");
      count_busy(0, n);
      chk(n == RC, "R6 recall length", 32'(n), RC);
      repeat (3) begin
        tick;
        chk(busy == 1'b0, "R5 held recall no retrigger", 32'(busy), 0);
      end
      desel; tick;
      copy_shad_to_live;
      verify_all("R4 recall contents");
    end

    // R6: pins ignored during store
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), DW'($urandom));
    start_op(0, 1, "R5 store after re-entry");
    count_busy(1, n);
    desel;
    chk(n == SC, "R6 store length under noise", 32'(n), SC);
    copy_live_to_shad;
    tick;
    verify_all("R6 writes ignored while busy");

    // R7: read state waiting at end of operation
    start_op(0, 1, "R7 store start");
    pins(0, 1, 0, 1); addr = 5;
    count_busy(0, n);
    chk(rdata_oe == 1'b0, "R7 bus still off at busy fall", 32'(rdata_oe), 0);
    tick;
    chk(rdata_oe == 1'b1, "R7 read active after op", 32'(rdata_oe), 1);
    chk(rdata == live_m[5], "R7 read data after op", 32'(rdata), 32'(live_m[5]));
    desel; tick;

    // R8: store inhibit
    pwr_below_inhibit = 1'b1;
    for (int a = 0; a < DEPTH; a += 2) do_write(AW'(a), DW'($urandom));
    pins(0, 0, 1, 0);
    repeat (4) begin
      tick;
      chk(busy == 1'b0, "R8 store inhibited", 32'(busy), 0);
    end
    pwr_below_inhibit = 1'b0;
    tick;
    chk(busy == 1'b0, "R8 no late store", 32'(busy), 0);
    desel; tick;
    start_op(1, 0, "R8 recall start");
    count_busy(0, n);
    desel; tick;
    copy_shad_to_live;
    verify_all("R8 shadow kept old contents");

    // R9: brown-out above reset level gives no recall
    for (int a = 0; a < DEPTH; a += 4) do_write(AW'(a), DW'($urandom));
    pwr_sense_ok = 1'b0;
    repeat (5) begin
      tick;
      chk(busy == 1'b0, "R9 shallow dip no recall", 32'(busy), 0);
    end
    pwr_sense_ok = 1'b1;
    tick;
    chk(busy == 1'b0, "R9 shallow dip recovery", 32'(busy), 0);
    do_read(0, "R9 data kept after shallow dip");

    // R9: deep brown-out latches recall
    pwr_sense_ok = 1'b0; pwr_below_reset = 1'b1;
    tick;
    chk(busy == 1'b1, "R9 pending after deep dip", 32'(busy), 1);
    pwr_below_reset = 1'b0;
    repeat (3) tick;
    chk(busy == 1'b1, "R9 pending held", 32'(busy), 1);
    pwr_sense_ok = 1'b1;
    tick;
    count_busy(0, n);
    chk(n == RS, "R9 restore length", 32'(n), RS);
    copy_shad_to_live;
    verify_all("R9 restore contents");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule